// File: doc/BRIEF.md
# Compound Operand Forwarding Controller

This block decides whether a freshly produced result can be handed straight to the next instruction of the same dependent group ("compound"). A small lookup table, which can be rewritten at run time, links each producer slot to the slot of its successor in the compound and to the operand position that the result feeds. When a result arrives, the controller looks up the link and raises a request for the shared write port. It holds that request until the port is granted.

When the grant arrives, the controller inspects the ready bits of the successor. If every operand of the successor other than the forwarded one is already present, the value is forwarded and an acknowledge pulse is issued. If the successor is still waiting on some other operand, a cancel pulse is issued instead. The value then goes out on the ordinary write-back path, so that the successor later finds it as a normal ready operand. A result whose producer has no valid link is only written back.

The controller tracks one result at a time. A new result is refused until the current one has been resolved.

Top module: `cfwd_forward_ctrl`

## Requirements
- R1: After reset, res_ready is 1, and wp_req, fwd_ack, fwd_cancel and wb_valid are 0. Every link-table entry is invalid.
- R2: A result with res_valid and res_ready both 1 at a clock edge is accepted. From the next cycle, wp_req is 1 and res_ready is 0.
- R3: Without wp_gnt, wp_req stays 1 and res_ready stays 0 for as many cycles as the grant is withheld. A result offered in that time is ignored: it produces no request and no output of its own.
- R4: A grant (wp_gnt while wp_req) for a producer with a valid link produces a one-cycle fwd_ack in the next cycle when all other operands of the linked consumer are ready. fwd_slot and fwd_opnd then carry the link's consumer slot and operand, fwd_data carries the result value, and wb_valid is 0.
- R5: Under the same grant, when any other operand of the consumer is not ready, the next cycle instead shows a one-cycle fwd_cancel with fwd_slot and fwd_opnd. In that same cycle wb_valid is 1, wb_slot is the producer slot and wb_data is the result value. fwd_data is 0.
- R6: A grant for a producer whose link entry is invalid gives only wb_valid, wb_slot and wb_data in the next cycle, with fwd_ack and fwd_cancel both 0.
- R7: Writing the table (lt_we with lt_idx, lt_valid, lt_next, lt_opnd) changes the entry from the next cycle. The link is captured when the result is accepted, so a rewrite while a result is pending does not change how that result resolves.
- R8: fwd_ack and fwd_cancel are never 1 together. Each grant yields exactly one completion cycle, after which wp_req is 0 and res_ready is 1. Unused output data fields read 0.
- R9: wp_gnt while wp_req is 0 has no effect on any output.
- R10: The ready bit of consumer slot s, operand k is opnd_rdy[s*NOPS+k]. The ready bit of the operand being forwarded is ignored in the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lt_we | input | 1 | Link-table write enable |
| lt_idx | input | SW | Producer slot whose entry is written |
| lt_valid | input | 1 | Valid bit written to the entry |
| lt_next | input | SW | Consumer slot written to the entry |
| lt_opnd | input | OW | Consumer operand position written to the entry |
| res_valid | input | 1 | Result offered |
| res_slot | input | SW | Producer slot of the result |
| res_data | input | DW | Result value |
| res_ready | output | 1 | Controller can accept a result |
| opnd_rdy | input | NSLOT*NOPS | Per-slot, per-operand ready bits |
| wp_req | output | 1 | Write-port request |
| wp_gnt | input | 1 | Write-port grant |
| fwd_ack | output | 1 | Forwarding accepted (one cycle) |
| fwd_cancel | output | 1 | Forwarding refused (one cycle) |
| fwd_slot | output | SW | Consumer slot addressed |
| fwd_opnd | output | OW | Consumer operand addressed |
| fwd_data | output | DW | Forwarded value, 0 unless fwd_ack |
| wb_valid | output | 1 | Normal write-back of the result |
| wb_slot | output | SW | Producer slot written back |
| wb_data | output | DW | Written-back value, 0 unless wb_valid |

## Verification
The decision is tested with four ready patterns:
- the other operand ready and the forwarded operand not ready, which must acknowledge;
- the forwarded operand ready and the other one not ready, which must cancel;
- no link, which must only write back;
- a link rewritten while a result is pending, which separates capture at acceptance from lookup at grant.

A grant delayed by several cycles, with a second result offered in that time, shows that the request is held and the second result is dropped. A grant with no request shows that stray grants are inert.

// File: rtl/cfwd_pkg.sv
package cfwd_pkg;

  localparam int MAXOPS = 8;

  typedef enum logic [1:0] {
    CMP_NONE   = 2'd0,
    CMP_ACK    = 2'd1,
    CMP_CANCEL = 2'd2,
    CMP_WB     = 2'd3
  } cmp_kind_e;

  // True when every operand other than 'skip' among the first 'nops' is ready.
  function automatic logic others_ready(input logic [MAXOPS-1:0] ops,
                                        input int unsigned nops,
                                        input int unsigned skip);
    logic r;
    r = 1'b1;
    for (int i = 0; i < MAXOPS; i++) begin
      if (i < int'(nops) && i != int'(skip) && !ops[i]) r = 1'b0;
    end
    return r;
  endfunction

  function automatic cmp_kind_e classify(input logic link_ok, input logic oth_rdy);
    if (!link_ok) return CMP_WB;
    if (oth_rdy) return CMP_ACK;
    return CMP_CANCEL;
  endfunction

endpackage

// File: rtl/cfwd_link_table.sv
module cfwd_link_table #(
  parameter int NSLOT = 8,
  parameter int SW    = 3,
  parameter int OW    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_idx,
  input  logic          wr_valid,
  input  logic [SW-1:0] wr_next,
  input  logic [OW-1:0] wr_opnd,
  input  logic [SW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [SW-1:0] rd_next,
  output logic [OW-1:0] rd_opnd
);

  logic [NSLOT-1:0] ent_valid;
  logic [SW-1:0]    ent_next [NSLOT];
  logic [OW-1:0]    ent_opnd [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_next[g]  <= '0;
        ent_opnd[g]  <= '0;
      end else if (wr_en && wr_idx == SW'(g)) begin
        ent_valid[g] <= wr_valid;
        ent_next[g]  <= wr_next;
        ent_opnd[g]  <= wr_opnd;
      end
    end
  end

  assign rd_valid = ent_valid[rd_idx];
  assign rd_next  = ent_next[rd_idx];
  assign rd_opnd  = ent_opnd[rd_idx];

endmodule

// File: rtl/cfwd_req_ctrl.sv
module cfwd_req_ctrl #(
  parameter int SW = 3,
  parameter int OW = 1,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          take,
  input  logic [SW-1:0] in_slot,
  input  logic [DW-1:0] in_data,
  input  logic          in_link,
  input  logic [SW-1:0] in_next,
  input  logic [OW-1:0] in_opnd,
  output logic          pending,
  output logic [SW-1:0] p_slot,
  output logic [DW-1:0] p_data,
  output logic          p_link,
  output logic [SW-1:0] p_next,
  output logic [OW-1:0] p_opnd
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      p_slot  <= '0;
      p_data  <= '0;
      p_link  <= 1'b0;
      p_next  <= '0;
      p_opnd  <= '0;
    end else if (accept) begin
      pending <= 1'b1;
      p_slot  <= in_slot;
      p_data  <= in_data;
      p_link  <= in_link;
      p_next  <= in_next;
      p_opnd  <= in_opnd;
    end else if (take) begin
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/cfwd_resolve.sv
module cfwd_resolve
  import cfwd_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int NOPS  = 2,
  parameter int SW    = 3,
  parameter int OW    = 1,
  parameter int DW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [SW-1:0]     p_slot,
  input  logic [DW-1:0]     p_data,
  input  logic              p_link,
  input  logic [SW-1:0]     p_next,
  input  logic [OW-1:0]     p_opnd,
  input  logic [NSLOT*NOPS-1:0] opnd_rdy,
  output cmp_kind_e         kind,
  output logic              fwd_ack,
  output logic              fwd_cancel,
  output logic [SW-1:0]     fwd_slot,
  output logic [OW-1:0]     fwd_opnd,
  output logic [DW-1:0]     fwd_data,
  output logic              wb_valid,
  output logic [SW-1:0]     wb_slot,
  output logic [DW-1:0]     wb_data
);

  logic [MAXOPS-1:0] cons_ops;
  logic              oth_rdy;

  always_comb begin
    cons_ops = '0;
    cons_ops[NOPS-1:0] = opnd_rdy[p_next*NOPS +: NOPS];
    oth_rdy = others_ready(cons_ops, NOPS, int'(p_opnd));
    kind    = take ? classify(p_link, oth_rdy) : CMP_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_ack    <= 1'b0;
      fwd_cancel <= 1'b0;
      fwd_slot   <= '0;
      fwd_opnd   <= '0;
      fwd_data   <= '0;
      wb_valid   <= 1'b0;
      wb_slot    <= '0;
      wb_data    <= '0;
    end else begin
      fwd_ack    <= (kind == CMP_ACK);
      fwd_cancel <= (kind == CMP_CANCEL);
      fwd_slot   <= (kind == CMP_ACK || kind == CMP_CANCEL) ? p_next : '0;
      fwd_opnd   <= (kind == CMP_ACK || kind == CMP_CANCEL) ? p_opnd : '0;
      fwd_data   <= (kind == CMP_ACK) ? p_data : '0;
      wb_valid   <= (kind == CMP_CANCEL || kind == CMP_WB);
      wb_slot    <= (kind == CMP_CANCEL || kind == CMP_WB) ? p_slot : '0;
      wb_data    <= (kind == CMP_CANCEL || kind == CMP_WB) ? p_data : '0;
    end
  end

endmodule

// File: rtl/cfwd_forward_ctrl.sv
module cfwd_forward_ctrl
  import cfwd_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int NOPS  = 2,
  parameter int DW    = 16,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int OW   = (NOPS > 1) ? $clog2(NOPS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lt_we,
  input  logic [SW-1:0]         lt_idx,
  input  logic                  lt_valid,
  input  logic [SW-1:0]         lt_next,
  input  logic [OW-1:0]         lt_opnd,
  input  logic                  res_valid,
  input  logic [SW-1:0]         res_slot,
  input  logic [DW-1:0]         res_data,
  output logic                  res_ready,
  input  logic [NSLOT*NOPS-1:0] opnd_rdy,
  output logic                  wp_req,
  input  logic                  wp_gnt,
  output logic                  fwd_ack,
  output logic                  fwd_cancel,
  output logic [SW-1:0]         fwd_slot,
  output logic [OW-1:0]         fwd_opnd,
  output logic [DW-1:0]         fwd_data,
  output logic                  wb_valid,
  output logic [SW-1:0]         wb_slot,
  output logic [DW-1:0]         wb_data
);

  logic          lk_valid;
  logic [SW-1:0] lk_next;
  logic [OW-1:0] lk_opnd;
  logic          pending;
  logic [SW-1:0] p_slot;
  logic [DW-1:0] p_data;
  logic          p_link;
  logic [SW-1:0] p_next;
  logic [OW-1:0] p_opnd;
  logic          accept_ev;
  logic          take_ev;
  cmp_kind_e     kind;

  assign res_ready = !pending;
  assign wp_req    = pending;
  assign accept_ev = res_valid && res_ready;
  assign take_ev   = pending && wp_gnt;

  cfwd_link_table #(.NSLOT(NSLOT), .SW(SW), .OW(OW)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(lt_we), .wr_idx(lt_idx), .wr_valid(lt_valid),
    .wr_next(lt_next), .wr_opnd(lt_opnd),
    .rd_idx(res_slot), .rd_valid(lk_valid), .rd_next(lk_next), .rd_opnd(lk_opnd)
  );

  cfwd_req_ctrl #(.SW(SW), .OW(OW), .DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n),
    .accept(accept_ev), .take(take_ev),
    .in_slot(res_slot), .in_data(res_data),
    .in_link(lk_valid), .in_next(lk_next), .in_opnd(lk_opnd),
    .pending(pending), .p_slot(p_slot), .p_data(p_data),
    .p_link(p_link), .p_next(p_next), .p_opnd(p_opnd)
  );

  cfwd_resolve #(.NSLOT(NSLOT), .NOPS(NOPS), .SW(SW), .OW(OW), .DW(DW)) u_res (
    .clk(clk), .rst_n(rst_n), .take(take_ev),
    .p_slot(p_slot), .p_data(p_data), .p_link(p_link),
    .p_next(p_next), .p_opnd(p_opnd), .opnd_rdy(opnd_rdy),
    .kind(kind),
    .fwd_ack(fwd_ack), .fwd_cancel(fwd_cancel), .fwd_slot(fwd_slot),
    .fwd_opnd(fwd_opnd), .fwd_data(fwd_data),
    .wb_valid(wb_valid), .wb_slot(wb_slot), .wb_data(wb_data)
  );

endmodule

// File: rtl/cfwd_forward_chk.sv
module cfwd_forward_chk (
  input logic clk,
  input logic rst_n,
  input logic res_valid,
  input logic res_ready,
  input logic wp_req,
  input logic wp_gnt,
  input logic fwd_ack,
  input logic fwd_cancel,
  input logic wb_valid
);

  // R2
  accept_raises_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (wp_req && !res_ready));

  // R3
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_req && !wp_gnt) |=> wp_req);

  // R3
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_req |-> !res_ready);

  // R8
  ack_cancel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_ack && fwd_cancel));

  // R4
  ack_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ack |-> !wb_valid);

  // R5
  cancel_writes_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_cancel |-> wb_valid);

  // R9
  completion_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_ack || fwd_cancel || wb_valid) |-> $past(wp_req && wp_gnt));

  // R8
  grant_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_req && wp_gnt) |=> (!wp_req && (fwd_ack || fwd_cancel || wb_valid)));

endmodule

bind cfwd_forward_ctrl cfwd_forward_chk u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
  .wp_req(wp_req), .wp_gnt(wp_gnt), .fwd_ack(fwd_ack),
  .fwd_cancel(fwd_cancel), .wb_valid(wb_valid)
);

// File: tb/cfwd_forward_ctrl_tb.sv
module cfwd_forward_ctrl_tb_top;

  localparam int CLK_T = 10;
  localparam int NSLOT = 8;
  localparam int NOPS  = 2;
  localparam int DW    = 16;
  localparam int SW    = 3;
  localparam int OW    = 1;

  localparam int K_ACK = 1;
  localparam int K_CAN = 2;
  localparam int K_WB  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lt_we = 1'b0;
  logic [SW-1:0] lt_idx = '0;
  logic lt_valid = 1'b0;
  logic [SW-1:0] lt_next = '0;
  logic [OW-1:0] lt_opnd = '0;
  logic res_valid = 1'b0;
  logic [SW-1:0] res_slot = '0;
  logic [DW-1:0] res_data = '0;
  logic res_ready;
  logic [NSLOT*NOPS-1:0] opnd_rdy = '0;
  logic wp_req;
  logic wp_gnt = 1'b0;
  logic fwd_ack, fwd_cancel, wb_valid;
  logic [SW-1:0] fwd_slot, wb_slot;
  logic [OW-1:0] fwd_opnd;
  logic [DW-1:0] fwd_data, wb_data;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  cfwd_forward_ctrl #(.NSLOT(NSLOT), .NOPS(NOPS), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lt_we(lt_we), .lt_idx(lt_idx), .lt_valid(lt_valid),
    .lt_next(lt_next), .lt_opnd(lt_opnd),
    .res_valid(res_valid), .res_slot(res_slot), .res_data(res_data),
    .res_ready(res_ready), .opnd_rdy(opnd_rdy),
    .wp_req(wp_req), .wp_gnt(wp_gnt),
    .fwd_ack(fwd_ack), .fwd_cancel(fwd_cancel), .fwd_slot(fwd_slot),
    .fwd_opnd(fwd_opnd), .fwd_data(fwd_data),
    .wb_valid(wb_valid), .wb_slot(wb_slot), .wb_data(wb_data)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(string req);
    check(req, "fwd_ack", int'(fwd_ack), 0);
    check(req, "fwd_cancel", int'(fwd_cancel), 0);
    check(req, "wb_valid", int'(wb_valid), 0);
    check(req, "fwd_data", int'(fwd_data), 0);
    check(req, "wb_data", int'(wb_data), 0);
  endtask

  task automatic prog(int idx, bit v, int nxt, int op);
    lt_we = 1'b1; lt_idx = SW'(idx); lt_valid = v;
    lt_next = SW'(nxt); lt_opnd = OW'(op);
    step();
    lt_we = 1'b0;
  endtask

  task automatic set_rdy(int slot, int op, bit v);
    opnd_rdy[slot*NOPS+op] = v;
  endtask

  task automatic offer(int slot, int data);
    res_valid = 1'b1; res_slot = SW'(slot); res_data = DW'(data);
    step();
    res_valid = 1'b0;
  endtask

  // Grant now and check the completion cycle against the expected kind.
  task automatic grant_and_check(string req, int kind, int pslot, int data, int cslot, int cop);
    wp_gnt = 1'b1;
    step();
    wp_gnt = 1'b0;
    check(req, "fwd_ack", int'(fwd_ack), kind == K_ACK);
    check(req, "fwd_cancel", int'(fwd_cancel), kind == K_CAN);
    check(req, "wb_valid", int'(wb_valid), kind != K_ACK);
    if (kind != K_WB) begin
      check(req, "fwd_slot", int'(fwd_slot), cslot);
      check(req, "fwd_opnd", int'(fwd_opnd), cop);
    end
    check(req, "fwd_data", int'(fwd_data), kind == K_ACK ? data : 0);
    if (kind != K_ACK) begin
      check(req, "wb_slot", int'(wb_slot), pslot);
      check(req, "wb_data", int'(wb_data), data);
    end else begin
      check(req, "wb_data", int'(wb_data), 0);
    end
    check("R8", "wp_req after grant", int'(wp_req), 0);
    check("R8", "res_ready after grant", int'(res_ready), 1);
    step();
    check_idle("R8");
  endtask

  task automatic t_reset();
    step();
    check("R1", "res_ready in reset", int'(res_ready), 1);
    check("R1", "wp_req in reset", int'(wp_req), 0);
    rst_n = 1'b1;
    step();
    check("R1", "res_ready", int'(res_ready), 1);
    check("R1", "wp_req", int'(wp_req), 0);
    check_idle("R1");
  endtask

  task automatic t_empty_table();
    offer(6, 16'h0042);
    check("R2", "wp_req", int'(wp_req), 1);
    check("R2", "res_ready", int'(res_ready), 0);
    grant_and_check("R1", K_WB, 6, 16'h0042, 0, 0);
  endtask

  task automatic t_ack();
    prog(0, 1'b1, 3, 1);
    set_rdy(3, 0, 1'b1);
    set_rdy(3, 1, 1'b0);
    offer(0, 16'hA5A5);
    check("R2", "wp_req", int'(wp_req), 1);
    grant_and_check("R4", K_ACK, 0, 16'hA5A5, 3, 1);
  endtask

  task automatic t_cancel();
    prog(1, 1'b1, 4, 0);
    set_rdy(4, 0, 1'b1);
    set_rdy(4, 1, 1'b0);
    offer(1, 16'h1234);
    grant_and_check("R5", K_CAN, 1, 16'h1234, 4, 0);
    // R10: forwarded operand not ready, other ready -> still ack
    set_rdy(4, 0, 1'b0);
    set_rdy(4, 1, 1'b1);
    offer(1, 16'h0777);
    grant_and_check("R10", K_ACK, 1, 16'h0777, 4, 0);
  endtask

  task automatic t_nolink();
    prog(5, 1'b0, 2, 1);
    set_rdy(2, 0, 1'b1);
    set_rdy(2, 1, 1'b1);
    offer(5, 16'h00FE);
    grant_and_check("R6", K_WB, 5, 16'h00FE, 0, 0);
  endtask

  task automatic t_hold();
    offer(0, 16'h0B0B);
    for (int i = 0; i < 3; i++) begin
      res_valid = 1'b1; res_slot = 3'd5; res_data = 16'hDEAD;
      step();
      check("R3", "wp_req held", int'(wp_req), 1);
      check("R3", "res_ready low", int'(res_ready), 0);
      check_idle("R3");
    end
    res_valid = 1'b0;
    grant_and_check("R3", K_ACK, 0, 16'h0B0B, 3, 1);
    check("R3", "no request from ignored result", int'(wp_req), 0);
  endtask

  task automatic t_stray_grant();
    wp_gnt = 1'b1;
    step();
    step();
    wp_gnt = 1'b0;
    check("R9", "wp_req", int'(wp_req), 0);
    check_idle("R9");
  endtask

  task automatic t_update();
    prog(1, 1'b1, 6, 1);
    set_rdy(6, 0, 1'b1);
    set_rdy(6, 1, 1'b0);
    offer(1, 16'h6161);
    grant_and_check("R7", K_ACK, 1, 16'h6161, 6, 1);
    prog(2, 1'b1, 7, 0);
    set_rdy(7, 1, 1'b1);
    offer(2, 16'h7070);
    prog(2, 1'b0, 0, 0);
    check("R7", "still pending", int'(wp_req), 1);
    grant_and_check("R7", K_ACK, 2, 16'h7070, 7, 0);
    offer(2, 16'h2222);
    grant_and_check("R7", K_WB, 2, 16'h2222, 0, 0);
  endtask

  initial begin
    t_reset();
    t_empty_table();
    t_ack();
    t_cancel();
    t_nolink();
    t_hold();
    t_stray_grant();
    t_update();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_T*100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule